// File: doc/BRIEF.md
# Reloadable Clock Divider Controller

This block derives a divided clock from its parent clock with an integer ratio. Software programs it through a small word-wide register port. The divider keeps two copies of the ratio. Software writes the staged copy. The active copy runs the counter, and it changes only when software asks for it with a two-bit handshake in the control word.

A new ratio becomes active only when two control bits are both set: the per-clock reload-force bit and the global reload trigger bit. The transfer waits for the end of the current output period, so no high or low phase is ever cut short. The divider accepts only the ratios 4, 5, 6 and 8. A staged value outside that set is dropped at reload, and the previous active ratio keeps running.

A per-clock enable bit gates the output. The gate changes state only at a period boundary, which keeps the output free of glitches. Every register bit reads back the value last written, so software can update fields with read-modify-write.

Top module: `clkdiv_reload_ctrl`

## Requirements
- R1: After reset, the control word (byte address 0x0) reads 0x0200_0000 and the ratio word (byte address 0x8) reads 0x0000_0800. Both the staged ratio and the active ratio are 8, and the output runs enabled with 4 parent cycles high and 4 low.
- R2: The staged ratio is bits [13:8] of the ratio word at byte address 0x8. Writing this word never changes the running divider by itself.
- R3: The staged ratio is applied only while control bit 1 (reload-force) and control bit 8 (reload trigger) are both set. Either bit set alone leaves the active ratio unchanged.
- R4: The active ratio changes only at the end of a complete output period, when the counter returns to zero.
- R5: Only the ratios 4, 5, 6 and 8 are accepted at reload. Any other staged value, such as 7 or 0, is ignored, and the previous active ratio stays in use.
- R6: One output period lasts as many parent cycles as the active ratio. The high phase lasts floor(ratio/2) cycles and the low phase lasts the remaining cycles, so an odd ratio gives a high phase one cycle shorter than the low phase.
- R7: Writing the control word with bit 8 and bits [7:0] cleared ends the reload request without reverting the active ratio.
- R8: Control bit 25 enables the output. When the bit is clear, the output is held low. Setting or clearing the bit takes effect only at the start of an output period, and the bit reads back as the current enable state.
- R9: Every bit of the control word and of the ratio word reads back exactly as last written. Accesses to any other address are ignored on write and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| clk_out | output | 1 | Divided and gated output clock, driven from a register |

## Verification
The assertions assume that the write port holds a single write per strobe, with the address and data stable for that cycle. They also assume that software follows the reload handshake: it stages the ratio first, then raises both reload bits, then clears them after the new ratio has settled. The bench drives every write on the falling edge for exactly one cycle. It leaves the reload bits set for several full output periods before clearing them, and it never writes a ratio and a reload in the same cycle. Staged ratios outside the valid set go through the same handshake, so the rule that drops them is exercised.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int RATIO_W     = 6;
    localparam int RATIO_LSB   = 8;
    localparam int CLK_FIELD   = 1;
    localparam int FORCE_BIT   = CLK_FIELD;
    localparam int TRIG_BIT    = 8;
    localparam int EN_BIT      = CLK_FIELD + 24;
    localparam int CTRL_ADDR   = 0;
    localparam int RATIO_ADDR  = 8;
    localparam int RESET_RATIO = 8;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t cnt;
        ratio_t active;
        logic   gate;
        logic   out;
    } div_state_t;

    function automatic logic ratio_ok(input ratio_t r);
        return (r == ratio_t'(4)) || (r == ratio_t'(5)) ||
               (r == ratio_t'(6)) || (r == ratio_t'(8));
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ratio_t            staged_ratio,
    output logic              reload_force,
    output logic              reload_trig,
    output logic              out_enable
);

    localparam logic [DATA_W-1:0] CTRL_RST  = DATA_W'(1) << EN_BIT;
    localparam logic [DATA_W-1:0] RATIO_RST = DATA_W'(RESET_RATIO) << RATIO_LSB;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] ratio;
    } reg_state_t;

    reg_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(CTRL_ADDR))  r_d.ctrl  = wr_data;
            if (wr_addr == ADDR_W'(RATIO_ADDR)) r_d.ratio = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ctrl  <= CTRL_RST;
            r_q.ratio <= RATIO_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (rd_addr == ADDR_W'(CTRL_ADDR))       rd_data = r_q.ctrl;
        else if (rd_addr == ADDR_W'(RATIO_ADDR)) rd_data = r_q.ratio;
        else                                     rd_data = '0;
    end

    assign staged_ratio = r_q.ratio[RATIO_LSB +: RATIO_W];
    assign reload_force = r_q.ctrl[FORCE_BIT];
    assign reload_trig  = r_q.ctrl[TRIG_BIT];
    assign out_enable   = r_q.ctrl[EN_BIT];

    // R9: a control write lands in full
    p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> (r_q.ctrl == $past(wr_data)));

    // R2: ratio word only changes through a write to its address
    p_ratio_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_W'(RATIO_ADDR)) |=> $stable(r_q.ratio));

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_t staged_ratio,
    input  logic   reload_force,
    input  logic   reload_trig,
    input  logic   out_enable,
    output logic   clk_out
);

    div_state_t s_d, s_q;
    logic       wrap;
    logic       reload_req;

    assign wrap       = (s_q.cnt == s_q.active - ratio_t'(1));
    assign reload_req = reload_force && reload_trig;

    always_comb begin
        s_d = s_q;
        if (wrap) begin
            s_d.cnt  = '0;
            s_d.gate = out_enable;
            if (reload_req && ratio_ok(staged_ratio))
                s_d.active = staged_ratio;
        end else begin
            s_d.cnt = s_q.cnt + ratio_t'(1);
        end
        s_d.out = s_d.gate && (s_d.cnt < (s_d.active >> 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt    <= '0;
            s_q.active <= ratio_t'(RESET_RATIO);
            s_q.gate   <= 1'b1;
            s_q.out    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_out = s_q.out;

    // R5: only supported ratios ever become active
    p_active_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_ok(s_q.active));

    // R4: ratio switches only at a fresh period
    p_switch_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active != $past(s_q.active)) |-> (s_q.cnt == '0));

    // R3: no switch without both reload bits
    p_need_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reload_force && reload_trig) |=> $stable(s_q.active));

    // R8: gate moves only at a period start, and holds the output low
    p_gate_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.gate) |-> (s_q.cnt == '0));
    p_low_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.gate |-> !clk_out);

    // R6: counter stays inside the active period
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < s_q.active);

endmodule

// File: rtl/clkdiv_reload_ctrl.sv
module clkdiv_reload_ctrl
    import clkdiv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              clk_out
);

    ratio_t staged_ratio;
    logic   reload_force;
    logic   reload_trig;
    logic   out_enable;

    clkdiv_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .staged_ratio (staged_ratio),
        .reload_force (reload_force),
        .reload_trig  (reload_trig),
        .out_enable   (out_enable)
    );

    clkdiv_core core_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .staged_ratio (staged_ratio),
        .reload_force (reload_force),
        .reload_trig  (reload_trig),
        .out_enable   (out_enable),
        .clk_out      (clk_out)
    );

endmodule

// File: tb/clkdiv_reload_ctrl_tb_top.sv
module clkdiv_reload_ctrl_tb_top;

    localparam logic [31:0] EN    = 32'h0200_0000;
    localparam logic [31:0] FORCE = 32'h0000_0002;
    localparam logic [31:0] TRIG  = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        clk_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    clkdiv_reload_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .clk_out(clk_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // high and low length of one full output period, from rise to rise
    task automatic measure(output int hi, output int lo);
        logic prev;
        prev = 1'b1;
        @(negedge clk);
        while (!(clk_out && !prev)) begin
            prev = clk_out;
            @(negedge clk);
        end
        hi = 0; lo = 0;
        while (clk_out) begin hi++; @(negedge clk); end
        while (!clk_out) begin lo++; @(negedge clk); end
    endtask

    task automatic expect_period(input string req, input int ehi, input int elo);
        int hi, lo;
        measure(hi, lo);
        measure(hi, lo);
        check(req, "high phase", hi, ehi);
        check(req, "low phase", lo, elo);
    endtask

    task automatic do_reload(input int r);
        wr(4'h8, 32'(r) << 8);
        wr(4'h0, EN | FORCE | TRIG);
        repeat (24) @(negedge clk);
        wr(4'h0, EN);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'h0, d); check("R1", "ctrl reset", d, 32'h0200_0000);
        rd(4'h8, d); check("R1", "ratio reset", d, 32'h0000_0800);
        expect_period("R1", 4, 4);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        wr(4'h0, 32'h5A3C_00F0);
        rd(4'h0, d); check("R9", "ctrl readback", d, 32'h5A3C_00F0);
        wr(4'h8, 32'hFFFF_C4AA);
        rd(4'h8, d); check("R9", "ratio readback", d, 32'hFFFF_C4AA);
        wr(4'h4, 32'hDEAD_BEEF);
        rd(4'h4, d); check("R9", "unmapped reads zero", d, 0);
        rd(4'h0, d); check("R9", "ctrl untouched by unmapped write", d, 32'h5A3C_00F0);
        wr(4'h0, EN);
        expect_period("R2", 4, 4);
    endtask

    task automatic t_handshake;
        wr(4'h8, 32'h0000_0500);
        repeat (20) @(negedge clk);
        expect_period("R2", 4, 4);
        wr(4'h0, EN | FORCE);
        expect_period("R3", 4, 4);
        wr(4'h0, EN | TRIG);
        expect_period("R3", 4, 4);
        wr(4'h0, EN | FORCE | TRIG);
        expect_period("R3", 2, 3);
        wr(4'h0, EN);
        expect_period("R7", 2, 3);
    endtask

    task automatic t_ratios;
        do_reload(6); expect_period("R6", 3, 3);
        do_reload(4); expect_period("R6", 2, 2);
        do_reload(7); expect_period("R5", 2, 2);
        do_reload(0); expect_period("R5", 2, 2);
        do_reload(8); expect_period("R6", 4, 4);
    endtask

    // R4: a switch during a long period waits for its end
    task automatic t_boundary;
        int hi, lo;
        measure(hi, lo);
        wr(4'h8, 32'h0000_0400);
        wr(4'h0, EN | FORCE | TRIG);
        // currently inside a /8 period; that period must finish intact
        while (clk_out) @(negedge clk);
        lo = 0;
        while (!clk_out) begin lo++; @(negedge clk); end
        check("R4", "low phase of the interrupted period", lo, 4);
        hi = 0;
        while (clk_out) begin hi++; @(negedge clk); end
        check("R4", "first high phase after switch", hi, 2);
        wr(4'h0, EN);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        int highs;
        wr(4'h0, 32'h0);
        rd(4'h0, d); check("R8", "enable bit reads clear", int'(d[25]), 0);
        repeat (10) @(negedge clk);
        highs = 0;
        repeat (40) begin @(negedge clk); if (clk_out) highs++; end
        check("R8", "output held low when disabled", highs, 0);
        wr(4'h0, EN);
        rd(4'h0, d); check("R8", "enable bit reads set", int'(d[25]), 1);
        expect_period("R8", 2, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_handshake();
        t_ratios();
        t_boundary();
        t_enable();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule